// File: doc/BRIEF.md
# I2C Dual Slave Address Matcher

This block decides whether a 7-bit slave address, already shifted in by the bit-level receiver, belongs to this device. It holds two own-addresses. The primary address is compared exactly. The secondary address can have a number of its low-order bits treated as don't-care, chosen by a 3-bit mask code. Each address has its own enable.

Whenever the secondary mask code is nonzero, the two reserved 7-bit ranges (top four bits all zero or all one) are refused, even when every bit that is still compared matches. While the secondary enable is set, the secondary address and mask code are locked, and writes to them are dropped. To change them, software first clears the enable.

Received addresses arrive on a valid/ready stream. Ready is held high, so the block never applies back-pressure: a beat transfers in every cycle where valid is high. The verdict is a one-cycle pulse with a flag that tells which address matched.

Top module: `i2c_dual_addr_match`

## Requirements
- R1: After reset, `match_pulse` and `match_sec` are 0, both enables are clear, and no address is acknowledged until the configuration is written.
- R2: With the primary enable set, an address equal to the primary address is acknowledged. With the primary enable clear, the primary address never matches.
- R3: With the secondary enable set and mask code 0, only an exact match to the secondary address is acknowledged. The reserved ranges are not excluded in this case.
- R4: A mask code n from 1 to 6 makes the n least-significant address bits don't-care in the secondary comparison.
- R5: Mask code 7 makes every secondary bit don't-care. Every address matches except the reserved ones.
- R6: With a nonzero mask code, addresses 7'b0000xxx and 7'b1111xxx never produce a secondary match.
- R7: When both addresses match, `match_sec` is 0, because the primary address takes priority. `match_sec` is 1 only for a secondary-only match, and only while `match_pulse` is 1.
- R8: `addr_ready` is always 1. `match_pulse` is high for exactly the one cycle that follows a cycle with `addr_valid` high and a matching address. It is low in every other cycle.
- R9: While the stored secondary enable is 1, a secondary write leaves the secondary address and mask code unchanged and updates only the enable.
- R10: With the secondary enable clear, the secondary address never matches, whatever the mask code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_valid | input | 1 | Received address beat valid |
| addr_ready | output | 1 | Always 1; the block never stalls |
| addr_data | input | 7 | Received 7-bit address |
| pri_we | input | 1 | Write strobe for the primary address and its enable |
| pri_addr_in | input | 7 | New primary address |
| pri_en_in | input | 1 | New primary enable |
| sec_we | input | 1 | Write strobe for the secondary address, mask code and enable |
| sec_addr_in | input | 7 | New secondary address |
| sec_mask_in | input | 3 | New mask code (number of don't-care LSBs, 7 = all) |
| sec_en_in | input | 1 | New secondary enable |
| match_pulse | output | 1 | One-cycle acknowledge verdict |
| match_sec | output | 1 | 1 when the secondary address alone matched |

## Verification
The bench builds the block with its default widths: a 7-bit address, a 3-bit mask code and a 4-bit reserved-range prefix. These widths keep the address space small enough to sweep all 128 addresses under every one of the eight mask codes, with the primary enable both clear and set. That sweep reaches every reserved address under every code, and every overlap between the primary and secondary matches. Random traffic interleaves configuration writes with addresses, so dropped writes under the lock and back-to-back beats are exercised as well.

// File: rtl/addr_match_pkg.sv
package addr_match_pkg;
  localparam int ADDR_W_DEF = 7;
  localparam int MASK_W_DEF = 3;
  localparam int RSV_W_DEF  = 4;

  typedef enum logic {
    HIT_PRI = 1'b0,
    HIT_SEC = 1'b1
  } hit_src_e;
endpackage

// File: rtl/amatch_cfg.sv
module amatch_cfg #(
  parameter int ADDR_W = addr_match_pkg::ADDR_W_DEF,
  parameter int MASK_W = addr_match_pkg::MASK_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pri_we,
  input  logic [ADDR_W-1:0] pri_addr_in,
  input  logic              pri_en_in,
  input  logic              sec_we,
  input  logic [ADDR_W-1:0] sec_addr_in,
  input  logic [MASK_W-1:0] sec_mask_in,
  input  logic              sec_en_in,
  output logic [ADDR_W-1:0] pri_addr_q,
  output logic              pri_en_q,
  output logic [ADDR_W-1:0] sec_addr_q,
  output logic [MASK_W-1:0] sec_mask_q,
  output logic              sec_en_q
);
  logic sec_unlocked;
  assign sec_unlocked = sec_we && !sec_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_addr_q <= '0;
      pri_en_q   <= 1'b0;
    end else if (pri_we) begin
      pri_addr_q <= pri_addr_in;
      pri_en_q   <= pri_en_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_addr_q <= '0;
      sec_mask_q <= '0;
      sec_en_q   <= 1'b0;
    end else begin
      if (sec_unlocked) begin
        sec_addr_q <= sec_addr_in;
        sec_mask_q <= sec_mask_in;
      end
      if (sec_we) sec_en_q <= sec_en_in;
    end
  end

  AST_SEC_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sec_en_q) |-> ($stable(sec_addr_q) && $stable(sec_mask_q))); // R9
endmodule

// File: rtl/amatch_cmp.sv
module amatch_cmp #(
  parameter int ADDR_W = addr_match_pkg::ADDR_W_DEF,
  parameter int MASK_W = addr_match_pkg::MASK_W_DEF,
  parameter int RSV_W  = addr_match_pkg::RSV_W_DEF
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] pri_addr,
  input  logic              pri_en,
  input  logic [ADDR_W-1:0] sec_addr,
  input  logic [MASK_W-1:0] sec_mask,
  input  logic              sec_en,
  output logic              pri_hit,
  output logic              sec_hit
);
  localparam int CODE_W = 32;

  logic [ADDR_W-1:0] care;
  logic [RSV_W-1:0]  prefix;
  logic              reserved;
  logic              masking;
  logic              bits_eq;

  for (genvar g = 0; g < ADDR_W; g++) begin : g_care
    assign care[g] = (CODE_W'(sec_mask) <= CODE_W'(g));
  end

  assign prefix   = addr[ADDR_W-1 -: RSV_W];
  assign reserved = (&prefix) || (~|prefix);
  assign masking  = |sec_mask;
  assign bits_eq  = ((addr ^ sec_addr) & care) == '0;

  assign pri_hit = pri_en && (addr == pri_addr);
  assign sec_hit = sec_en && bits_eq && !(masking && reserved);

  always_comb begin
    AST_RSV_REFUSED: assert (!(sec_hit && masking && reserved)); // R6
    AST_SEC_OFF: assert (sec_en || !sec_hit); // R10
  end
endmodule

// File: rtl/i2c_dual_addr_match.sv
module i2c_dual_addr_match #(
  parameter int ADDR_W = addr_match_pkg::ADDR_W_DEF,
  parameter int MASK_W = addr_match_pkg::MASK_W_DEF,
  parameter int RSV_W  = addr_match_pkg::RSV_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_valid,
  output logic              addr_ready,
  input  logic [ADDR_W-1:0] addr_data,
  input  logic              pri_we,
  input  logic [ADDR_W-1:0] pri_addr_in,
  input  logic              pri_en_in,
  input  logic              sec_we,
  input  logic [ADDR_W-1:0] sec_addr_in,
  input  logic [MASK_W-1:0] sec_mask_in,
  input  logic              sec_en_in,
  output logic              match_pulse,
  output logic              match_sec
);
  import addr_match_pkg::*;

  logic [ADDR_W-1:0] pri_addr_q, sec_addr_q;
  logic [MASK_W-1:0] sec_mask_q;
  logic              pri_en_q, sec_en_q;
  logic              pri_hit, sec_hit;
  hit_src_e          src_d;

  assign addr_ready = 1'b1;

  amatch_cfg #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .pri_we(pri_we), .pri_addr_in(pri_addr_in), .pri_en_in(pri_en_in),
    .sec_we(sec_we), .sec_addr_in(sec_addr_in), .sec_mask_in(sec_mask_in),
    .sec_en_in(sec_en_in),
    .pri_addr_q(pri_addr_q), .pri_en_q(pri_en_q),
    .sec_addr_q(sec_addr_q), .sec_mask_q(sec_mask_q), .sec_en_q(sec_en_q)
  );

  amatch_cmp #(.ADDR_W(ADDR_W), .MASK_W(MASK_W), .RSV_W(RSV_W)) u_cmp (
    .addr(addr_data), .pri_addr(pri_addr_q), .pri_en(pri_en_q),
    .sec_addr(sec_addr_q), .sec_mask(sec_mask_q), .sec_en(sec_en_q),
    .pri_hit(pri_hit), .sec_hit(sec_hit)
  );

  assign src_d = pri_hit ? HIT_PRI : HIT_SEC;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_pulse <= 1'b0;
      match_sec   <= 1'b0;
    end else begin
      match_pulse <= addr_valid && (pri_hit || sec_hit);
      match_sec   <= addr_valid && sec_hit && (src_d == HIT_SEC);
    end
  end

  AST_PULSE_NEEDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> $past(addr_valid)); // R8
  AST_SEC_FLAG_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    match_sec |-> match_pulse); // R7
  AST_PRI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && pri_en_q && (addr_data == pri_addr_q)) |=> (match_pulse && !match_sec)); // R7
  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ready); // R8
endmodule

// File: tb/i2c_dual_addr_match_bench.sv
module i2c_dual_addr_match_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_valid = 1'b0;
  logic       addr_ready;
  logic [6:0] addr_data = '0;
  logic       pri_we = 1'b0, pri_en_in = 1'b0;
  logic [6:0] pri_addr_in = '0;
  logic       sec_we = 1'b0, sec_en_in = 1'b0;
  logic [6:0] sec_addr_in = '0;
  logic [2:0] sec_mask_in = '0;
  logic       match_pulse, match_sec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [6:0] m_pri, m_sec;
  logic [2:0] m_mask;
  logic       m_pen, m_sen;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_dual_addr_match u_i2c_dual_addr_match (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_ready(addr_ready),
    .addr_data(addr_data), .pri_we(pri_we), .pri_addr_in(pri_addr_in),
    .pri_en_in(pri_en_in), .sec_we(sec_we), .sec_addr_in(sec_addr_in),
    .sec_mask_in(sec_mask_in), .sec_en_in(sec_en_in),
    .match_pulse(match_pulse), .match_sec(match_sec)
  );

  function automatic bit ref_pri(logic [6:0] a);
    return m_pen && (a == m_pri);
  endfunction

  function automatic bit ref_sec(logic [6:0] a);
    logic [6:0] care;
    bit rsv;
    for (int i = 0; i < 7; i++) care[i] = (i >= int'(m_mask));
    rsv = (a[6:3] == 4'b0000) || (a[6:3] == 4'b1111);
    return m_sen && (((a ^ m_sec) & care) == 7'd0) && !((m_mask != 0) && rsv);
  endfunction

  task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got pulse/sec=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic write_pri(logic [6:0] a, logic en);
    @(negedge clk);
    pri_we = 1'b1; pri_addr_in = a; pri_en_in = en;
    @(negedge clk);
    pri_we = 1'b0;
    m_pri = a; m_pen = en;
  endtask

  task automatic write_sec(logic [6:0] a, logic [2:0] mk, logic en);
    @(negedge clk);
    sec_we = 1'b1; sec_addr_in = a; sec_mask_in = mk; sec_en_in = en;
    @(negedge clk);
    sec_we = 1'b0;
    if (!m_sen) begin m_sec = a; m_mask = mk; end
    m_sen = en;
  endtask

  task automatic probe(logic [6:0] a);
    bit p, s;
    string tag;
    p = ref_pri(a);
    s = ref_sec(a);
    if (p)                                   tag = "R2 R7";
    else if (!m_sen)                         tag = "R10";
    else if (m_mask == 0)                    tag = "R3";
    else if (a[6:3] == 4'h0 || a[6:3] == 4'hf) tag = "R6";
    else if (m_mask == 7)                    tag = "R5";
    else                                     tag = "R4";
    @(negedge clk);
    addr_valid = 1'b1; addr_data = a;
    @(negedge clk);
    addr_valid = 1'b0;
    check(tag, {match_pulse, match_sec}, {p | s, s & ~p});
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_pri = '0; m_sec = '0; m_mask = '0; m_pen = 0; m_sen = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset outputs", {match_pulse, match_sec}, 2'b00);
    check("R8 ready", {1'b0, addr_ready}, 2'b01);
    rst_n = 1'b1;
    probe(7'h00);
    probe(7'h3a);

    // R8: the pulse lasts one cycle and needs a beat
    write_pri(7'h3a, 1'b1);
    probe(7'h3a);
    @(negedge clk);
    check("R8 pulse drops", {match_pulse, match_sec}, 2'b00);
    @(negedge clk);
    addr_data = 7'h3a;
    @(negedge clk);
    check("R8 no beat no pulse", {match_pulse, match_sec}, 2'b00);

    // R9: a locked write is dropped; the enable still updates
    write_sec(7'h55, 3'd0, 1'b1);
    write_sec(7'h22, 3'd7, 1'b1);
    probe(7'h55);
    probe(7'h22);
    write_sec(7'h22, 3'd7, 1'b0);
    probe(7'h55);
    write_sec(7'h22, 3'd0, 1'b1);
    probe(7'h22);
    @(negedge clk);
    check("R9 relock applied", {match_pulse, match_sec}, 2'b00);

    // R3: code 0 accepts a reserved address exactly
    write_sec(7'h02, 3'd0, 1'b0);
    write_sec(7'h02, 3'd0, 1'b1);
    probe(7'h02);
    probe(7'h03);

    // Full sweeps: every code, primary off and on
    for (int pe = 0; pe < 2; pe++) begin
      for (int mk = 0; mk < 8; mk++) begin
        write_pri(7'($urandom), pe[0]);
        write_sec(7'h00, 3'd0, 1'b0);
        write_sec(7'($urandom), 3'(mk), 1'b1);
        for (int a = 0; a < 128; a++) probe(7'(a));
      end
    end

    // R10: disabled secondary under code 7
    write_pri(7'h10, 1'b0);
    write_sec(7'h00, 3'd7, 1'b0);
    for (int a = 0; a < 128; a++) probe(7'(a));

    // Random mix of writes and beats
    for (int k = 0; k < 1500; k++) begin
      int r;
      r = int'($urandom % 10);
      if (r == 0)      write_pri(7'($urandom), 1'($urandom));
      else if (r == 1) write_sec(7'($urandom), 3'($urandom), 1'($urandom));
      else             probe(7'($urandom));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule